// File: doc/BRIEF.md
# Split-Capable 8-Bit Reloading Timer

This block is an 8-bit timer/counter built from a low counter and a high byte. In reload mode the high byte is a plain register that software fills through the load port; the low counter runs and, each time it wraps from all ones, takes the high byte's value as its new count and raises the primary overflow flag. This gives a periodic overflow whose period is set by the high byte alone.

In split mode the two bytes become independent 8-bit counters. The low counter keeps the primary run bit, gate select, counter/timer select and overflow flag, and wraps to zero. The high counter always counts machine-cycle ticks. It runs from the secondary run bit and raises the secondary overflow flag when it wraps. This gives a spare timer when the second timer of the chip does not need its own interrupt.

Both flags stay set until software clears them through dedicated clear inputs. Register writes use a one-byte load port with a strobe for each byte. Bus decoding and interrupt vectoring lie outside the block.

Top module: `split_reload_timer8`

## Requirements
- R1: After a synchronous reset both counts read 0x00 and both overflow flags read 0.
- R2: A load strobe writes the load data into the selected byte at the next clock edge.
- R3: In reload mode (split_mode = 0), a low-counter tick at count 0xFF sets ovf_a and loads the high byte's value into the low counter at the same edge. The high byte does not change.
- R4: The low counter advances only when run_a = 1 and either gate_sel = 0 or gate_pin = 1. In timer mode (ct_sel = 0) it advances once per clock with mc_en = 1.
- R5: In counter mode (ct_sel = 1) the low counter advances once for each 1-to-0 change of cnt_pin, seen over two consecutive clock samples. The count changes at the second clock edge after the pin falls, and mc_en has no effect.
- R6: In split mode the low counter wraps from 0xFF to 0x00 and sets ovf_a. It does not take the high byte's value.
- R7: In split mode the high counter advances on every clock with mc_en = 1 and run_b = 1, whatever ct_sel is. Its wrap from 0xFF to 0x00 sets ovf_b.
- R8: An overflow flag stays set until its clear input is pulsed. When a set and a clear fall in the same cycle, the flag ends up set.
- R9: In reload mode the high byte never counts, run_b has no effect, and ovf_b is not set.
- R10: A load strobe on a byte takes priority over a count of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| mc_en | input | 1 | Machine-cycle tick (one clock in twelve) |
| cnt_pin | input | 1 | External count input |
| gate_pin | input | 1 | External gate input for the low counter |
| run_a | input | 1 | Primary run bit |
| run_b | input | 1 | Secondary run bit (drives the high counter in split mode) |
| gate_sel | input | 1 | 1: low counter also needs gate_pin high |
| ct_sel | input | 1 | 0: low counter counts mc_en, 1: counts cnt_pin falls |
| split_mode | input | 1 | 0: reload mode, 1: split mode |
| ld_lo | input | 1 | Load strobe for the low counter |
| ld_hi | input | 1 | Load strobe for the high byte |
| ld_data | input | 8 | Load data |
| clr_a | input | 1 | Clear for ovf_a |
| clr_b | input | 1 | Clear for ovf_b |
| lo_count | output | 8 | Low counter value |
| hi_count | output | 8 | High byte value |
| ovf_a | output | 1 | Primary overflow flag |
| ovf_b | output | 1 | Secondary overflow flag |

## Verification
The bound checker watches several properties on every clock. It checks that the reload at 0xFF copies the high byte and raises ovf_a at the same edge. It also checks that the high byte holds still in reload mode, that a stopped low counter holds its count, and that the high counter steps by one in split mode. It checks that ovf_b stays low in reload mode and that a flag never drops without a clear. Some behaviour only the directed scenarios show. These are the two-sample lag of counter mode and that mc_en is ignored there. The scenarios also show that ct_sel has no effect on the split high counter, that a load beats a count in the same cycle, and that a set beats a clear.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic {
    MODE_RELOAD = 1'b0,
    MODE_SPLIT  = 1'b1
  } srt_mode_e;

  typedef enum logic {
    SRC_CYCLES = 1'b0,
    SRC_PIN    = 1'b1
  } srt_src_e;
endpackage

// File: rtl/srt_fall_detect.sv
module srt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] smp;

  always_ff @(posedge clk) begin
    if (rst) smp <= '0;
    else     smp <= {smp[LAST-1:0], pin};
  end

  // older sample high, newer sample low
  assign fall = smp[LAST] & ~smp[LAST-1];
endmodule

// File: rtl/srt_counter.sv
module srt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  input  logic [W-1:0] wrap_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign wrap = tick & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (wrap) cnt <= wrap_val;
    else if (tick) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/srt_flag.sv
module srt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/split_reload_timer8.sv
module split_reload_timer8 #(
  parameter int W          = 8,
  parameter int PIN_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mc_en,
  input  logic         cnt_pin,
  input  logic         gate_pin,
  input  logic         run_a,
  input  logic         run_b,
  input  logic         gate_sel,
  input  logic         ct_sel,
  input  logic         split_mode,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W-1:0] ld_data,
  input  logic         clr_a,
  input  logic         clr_b,
  output logic [W-1:0] lo_count,
  output logic [W-1:0] hi_count,
  output logic         ovf_a,
  output logic         ovf_b
);
  import srt_pkg::*;

  localparam int NFLAG = 2;

  srt_mode_e mode;
  srt_src_e  src;
  logic      pin_fall;
  logic      lo_tick, hi_tick, lo_wrap, hi_wrap;
  logic [W-1:0] lo_wrap_val;
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;

  assign mode = srt_mode_e'(split_mode);
  assign src  = srt_src_e'(ct_sel);

  srt_fall_detect #(.STAGES(PIN_STAGES)) fd_i (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(pin_fall)
  );

  always_comb begin
    lo_tick = 1'b0;
    if (run_a && (!gate_sel || gate_pin))
      lo_tick = (src == SRC_PIN) ? pin_fall : mc_en;
    hi_tick     = (mode == MODE_SPLIT) && run_b && mc_en;
    lo_wrap_val = (mode == MODE_SPLIT) ? '0 : hi_count;
  end

  srt_counter #(.W(W)) lo_i (
    .clk(clk), .rst(rst), .ld(ld_lo), .ld_val(ld_data),
    .tick(lo_tick), .wrap_val(lo_wrap_val),
    .cnt(lo_count), .wrap(lo_wrap)
  );

  srt_counter #(.W(W)) hi_i (
    .clk(clk), .rst(rst), .ld(ld_hi), .ld_val(ld_data),
    .tick(hi_tick), .wrap_val('0),
    .cnt(hi_count), .wrap(hi_wrap)
  );

  assign fl_set = {hi_wrap, lo_wrap};
  assign fl_clr = {clr_b, clr_a};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    srt_flag fl_i (
      .clk(clk), .rst(rst), .set(fl_set[g]), .clr(fl_clr[g]), .q(fl_q[g])
    );
  end

  assign ovf_a = fl_q[0];
  assign ovf_b = fl_q[1];
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mc_en,
  input logic         gate_pin,
  input logic         run_a,
  input logic         run_b,
  input logic         gate_sel,
  input logic         ct_sel,
  input logic         split_mode,
  input logic         ld_lo,
  input logic         ld_hi,
  input logic         clr_a,
  input logic [W-1:0] lo_count,
  input logic [W-1:0] hi_count,
  input logic         ovf_a,
  input logic         ovf_b
);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (!split_mode && !ld_lo && !ct_sel && mc_en && run_a &&
     (!gate_sel || gate_pin) && lo_count == ALL1)
    |=> (lo_count == $past(hi_count) && ovf_a));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!split_mode && !ld_hi) |=> (hi_count == $past(hi_count)));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_a && !ld_lo) |=> (lo_count == $past(lo_count)));

  p_hi_step_r7: assert property (@(posedge clk) disable iff (rst)
    (split_mode && run_b && mc_en && !ld_hi)
    |=> (hi_count == $past(hi_count) + ONE));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_a && !clr_a) |=> ovf_a);

  p_no_ovf_b_r9: assert property (@(posedge clk) disable iff (rst)
    (!split_mode && !ovf_b) |=> !ovf_b);
endmodule

bind split_reload_timer8 srt_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .mc_en(mc_en), .gate_pin(gate_pin),
  .run_a(run_a), .run_b(run_b), .gate_sel(gate_sel), .ct_sel(ct_sel),
  .split_mode(split_mode), .ld_lo(ld_lo), .ld_hi(ld_hi), .clr_a(clr_a),
  .lo_count(lo_count), .hi_count(hi_count), .ovf_a(ovf_a), .ovf_b(ovf_b)
);

// File: tb/split_reload_timer8_tb_top.sv
module split_reload_timer8_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_en = 0, cnt_pin = 1, gate_pin = 0, run_a = 0, run_b = 0;
  logic gate_sel = 0, ct_sel = 0, split_mode = 0, ld_lo = 0, ld_hi = 0;
  logic [7:0] ld_data = 8'h00;
  logic clr_a = 0, clr_b = 0;
  logic [7:0] lo_count, hi_count;
  logic ovf_a, ovf_b;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  split_reload_timer8 dut_i (
    .clk(clk), .rst(rst), .mc_en(mc_en), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .run_a(run_a), .run_b(run_b), .gate_sel(gate_sel), .ct_sel(ct_sel),
    .split_mode(split_mode), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
    .clr_a(clr_a), .clr_b(clr_b), .lo_count(lo_count), .hi_count(hi_count),
    .ovf_a(ovf_a), .ovf_b(ovf_b)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    run_a = 0; run_b = 0; mc_en = 0; gate_sel = 0; ct_sel = 0;
    ld_lo = 0; ld_hi = 0; clr_a = 0; clr_b = 0; cnt_pin = 1;
  endtask

  task automatic load(input logic [7:0] hi_v, input logic [7:0] lo_v);
    ld_hi = 1; ld_data = hi_v; cyc(1);
    ld_hi = 0; ld_lo = 1; ld_data = lo_v; cyc(1);
    ld_lo = 0;
  endtask

  task automatic clear_flags();
    clr_a = 1; clr_b = 1; cyc(1); clr_a = 0; clr_b = 0;
  endtask

  task automatic t_reset();
    chk("R1 lo", lo_count, 8'h00);
    chk("R1 hi", hi_count, 8'h00);
    chk("R1 flags", {6'd0, ovf_b, ovf_a}, 8'h00);
  endtask

  task automatic t_load();
    idle(); split_mode = 0;
    load(8'h5A, 8'hC3);
    chk("R2 hi", hi_count, 8'h5A);
    chk("R2 lo", lo_count, 8'hC3);
  endtask

  task automatic t_reload();
    idle(); split_mode = 0; load(8'h80, 8'hFD);
    run_a = 1; mc_en = 1;
    cyc(2);
    chk("R3 pre", lo_count, 8'hFF);
    chk("R3 flag pre", {7'd0, ovf_a}, 8'h00);
    cyc(1);
    chk("R3 reload", lo_count, 8'h80);
    chk("R3 flag", {7'd0, ovf_a}, 8'h01);
    chk("R3 hi kept", hi_count, 8'h80);
    cyc(1);
    chk("R3 after", lo_count, 8'h81);
    idle(); clear_flags();
  endtask

  task automatic t_gate();
    idle(); split_mode = 0; load(8'h00, 8'h10);
    mc_en = 1; run_a = 0; cyc(3);
    chk("R4 run off", lo_count, 8'h10);
    run_a = 1; gate_sel = 1; gate_pin = 0; cyc(3);
    chk("R4 gate low", lo_count, 8'h10);
    gate_pin = 1; cyc(3);
    chk("R4 gate high", lo_count, 8'h13);
    mc_en = 0; cyc(3);
    chk("R4 no tick", lo_count, 8'h13);
    gate_sel = 0; gate_pin = 0; mc_en = 1; cyc(2);
    chk("R4 gate ignored", lo_count, 8'h15);
    idle();
  endtask

  task automatic t_counter();
    idle(); split_mode = 0; load(8'h00, 8'h20);
    ct_sel = 1; run_a = 1; mc_en = 1; cnt_pin = 1; cyc(4);
    chk("R5 mc_en ignored", lo_count, 8'h20);
    cnt_pin = 0; cyc(1);
    chk("R5 one sample", lo_count, 8'h20);
    cyc(1);
    chk("R5 first fall", lo_count, 8'h21);
    cyc(4);
    chk("R5 held low", lo_count, 8'h21);
    cnt_pin = 1; cyc(2); cnt_pin = 0; cyc(2);
    chk("R5 second fall", lo_count, 8'h22);
    idle(); cyc(2);
  endtask

  task automatic t_split();
    idle(); split_mode = 1; load(8'hFE, 8'hFE);
    ct_sel = 1; cnt_pin = 1; run_a = 1; run_b = 1; mc_en = 1;
    cyc(1);
    chk("R7 hi step", hi_count, 8'hFF);
    cyc(1);
    chk("R7 hi wrap", hi_count, 8'h00);
    chk("R7 ovf_b", {7'd0, ovf_b}, 8'h01);
    chk("R7 lo untouched", lo_count, 8'hFE);
    chk("R7 ovf_a clear", {7'd0, ovf_a}, 8'h00);
    ct_sel = 0; cyc(2);
    chk("R6 lo wrap zero", lo_count, 8'h00);
    chk("R6 ovf_a", {7'd0, ovf_a}, 8'h01);
    chk("R6 hi ran on", hi_count, 8'h02);
    idle(); clear_flags();
    chk("R8 cleared", {6'd0, ovf_b, ovf_a}, 8'h00);
    split_mode = 0;
  endtask

  task automatic t_reload_hi();
    idle(); split_mode = 0; load(8'hFF, 8'h00);
    run_b = 1; mc_en = 1; cyc(4);
    chk("R9 hi frozen", hi_count, 8'hFF);
    chk("R9 no ovf_b", {7'd0, ovf_b}, 8'h00);
    idle();
  endtask

  task automatic t_flags();
    idle(); split_mode = 0; load(8'h40, 8'hFF);
    run_a = 1; mc_en = 1; cyc(1); run_a = 0;
    chk("R8 set", {7'd0, ovf_a}, 8'h01);
    cyc(3);
    chk("R8 sticky", {7'd0, ovf_a}, 8'h01);
    clr_a = 1; cyc(1); clr_a = 0;
    chk("R8 clear", {7'd0, ovf_a}, 8'h00);
    ld_lo = 1; ld_data = 8'hFF; cyc(1); ld_lo = 0;
    run_a = 1; clr_a = 1; cyc(1); run_a = 0; clr_a = 0;
    chk("R8 set wins", {7'd0, ovf_a}, 8'h01);
    idle(); clear_flags();
  endtask

  task automatic t_priority();
    idle(); split_mode = 0; load(8'h00, 8'h30);
    run_a = 1; mc_en = 1; cyc(1);
    chk("R10 counting", lo_count, 8'h31);
    ld_lo = 1; ld_data = 8'h10; cyc(1); ld_lo = 0;
    chk("R10 load wins", lo_count, 8'h10);
    idle();
  endtask

  initial begin
    cyc(3); rst = 0;
    t_reset();
    t_load();
    t_reload();
    t_gate();
    t_counter();
    t_split();
    t_reload_hi();
    t_flags();
    t_priority();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule